// File: doc/BRIEF.md
# Complementary PWM Dead-Band Generator

This block turns the single compare signal of one PWM channel into a pair of complementary gate drives, one for the high-side switch and one for the low-side switch. When dead-band insertion is on, the drive that is about to switch on waits a programmable number of channel clock-enable ticks. The drive that switches off drops at once. As a result the two switches are never on together. The high-side and low-side waits are set separately.

New wait values are written into a staging register. They are copied into the working registers only when the period-end strobe pulses, so a running period never sees a half-updated pair. The dead-band enable can only be changed while the channel is stopped. Each drive has its own polarity inversion, applied as the last stage. The channel comparator, the prescaler and the register bus sit outside this block and are seen here as plain input ports.

Top module: `pwm_deadband_gen`

## Requirements
- R1: With dead-band off, one clock after any compare change out_hi equals the compare value and out_lo equals its complement (before inversion).
- R2: With dead-band on, the two drives (before inversion) are never both high in the same cycle.
- R3: The drive that turns off goes low at the first clock edge after the compare edge, without any delay.
- R4: With dead-band on, on a rising compare edge the high drive arms at the first clock edge after the edge. It then goes high at the edge on which the N-th tick after arming is counted, where N is the working high-side value.
- R5: On a falling compare edge the low drive follows the same rule as R4, but uses the working low-side value. That value is independent of the high-side value.
- R6: The delay counter advances only on clock edges where tick is 1. Clock edges without tick add no progress.
- R7: A working value of zero makes the turning-on drive go high at the same edge at which the other drive goes low.
- R8: If the compare signal reverses before a pending delay has expired, the pending drive never goes high. The other drive starts a fresh delay from the reversal.
- R9: Values written with upd_wr have no effect until a period_end pulse. After that pulse they are used from the next clock edge on.
- R10: A write to the dead-band enable takes effect at the next clock edge only if chan_en is 0. While chan_en is 1 the write is ignored.
- R11: inv_hi and inv_lo each flip only their own output. A flipped output reads 1 when its drive is inactive.
- R12: Synchronous active-high reset clears both drives, turns dead-band off and clears both working values and both staged values. During reset, out_hi equals inv_hi and out_lo equals inv_lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Channel clock-enable; the delay counter advances only when it is 1 |
| chan_en | input | 1 | Channel running; blocks changes to the dead-band enable |
| cmp_in | input | 1 | Compare output of the channel |
| period_end | input | 1 | One-cycle strobe at the period boundary; copies staged values |
| en_wr | input | 1 | Write strobe for the dead-band enable |
| en_wdata | input | 1 | Enable value to write |
| upd_wr | input | 1 | Write strobe for the staged wait values |
| upd_hi | input | DT_W | Staged high-side wait, in ticks |
| upd_lo | input | DT_W | Staged low-side wait, in ticks |
| inv_hi | input | 1 | Invert out_hi |
| inv_lo | input | 1 | Invert out_lo |
| out_hi | output | 1 | High-side drive |
| out_lo | output | 1 | Low-side drive |

## Verification
The hardest case to reach from the ports is a compare reversal that arrives while a delay is still counting. In that case the armed drive must drop its pending turn-on, and the opposite drive must start a delay of its own. The stimulus gets there by raising the compare signal and lowering it again two clocks later, with a high-side wait of three. It then checks that the high drive stays low for the whole window and that the low drive comes up only after its full wait. A second hard case is a slow tick pattern (one tick every four clocks). For that case the bench computes the exact tick edges in advance, so it can confirm that clocks without a tick add no progress.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

    typedef enum logic {
        SIDE_HI = 1'b0,
        SIDE_LO = 1'b1
    } side_e;

    typedef struct packed {
        logic on;
        logic armed;
    } drive_st_t;

    function automatic logic side_want(side_e s, logic cmp);
        return (s == SIDE_HI) ? cmp : ~cmp;
    endfunction

endpackage

// File: rtl/pwm_db_enable.sv
module pwm_db_enable (
    input  logic clk,
    input  logic rst,
    input  logic chan_en,
    input  logic wr,
    input  logic wdata,
    output logic db_on
);
    always_ff @(posedge clk) begin
        if (rst) begin
            db_on <= 1'b0;
        end else if (wr && !chan_en) begin
            db_on <= wdata;
        end
    end
endmodule

// File: rtl/pwm_db_shadow.sv
module pwm_db_shadow #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            upd_wr,
    input  logic [DT_W-1:0] upd_hi,
    input  logic [DT_W-1:0] upd_lo,
    input  logic            period_end,
    output logic [DT_W-1:0] work_hi,
    output logic [DT_W-1:0] work_lo
);
    logic [DT_W-1:0] stage_hi;
    logic [DT_W-1:0] stage_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_hi <= '0;
            stage_lo <= '0;
        end else if (upd_wr) begin
            stage_hi <= upd_hi;
            stage_lo <= upd_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_hi <= '0;
            work_lo <= '0;
        end else if (period_end) begin
            work_hi <= stage_hi;
            work_lo <= stage_lo;
        end
    end
endmodule

// File: rtl/pwm_db_side.sv
module pwm_db_side
    import pwm_db_pkg::*;
#(
    parameter int    DT_W = 8,
    parameter side_e SIDE = SIDE_HI
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            db_on,
    input  logic            cmp_in,
    input  logic [DT_W-1:0] dt_val,
    output logic            drive,
    output logic            armed
);
    drive_st_t       st;
    logic [DT_W-1:0] cnt;
    logic [DT_W:0]   cnt_inc;
    logic            want;
    logic            expired;

    always_comb begin
        want    = side_want(SIDE, cmp_in);
        cnt_inc = {1'b0, cnt} + {{DT_W{1'b0}}, 1'b1};
        expired = (cnt_inc >= {1'b0, dt_val});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            cnt <= '0;
        end else if (!db_on) begin
            st.on    <= want;
            st.armed <= 1'b0;
            cnt      <= '0;
        end else if (!want) begin
            st  <= '0;
            cnt <= '0;
        end else if (st.on) begin
            st.armed <= 1'b0;
        end else if (!st.armed) begin
            cnt <= '0;
            if (dt_val == '0) begin
                st.on <= 1'b1;
            end else begin
                st.armed <= 1'b1;
            end
        end else if (tick) begin
            if (expired) begin
                st.on    <= 1'b1;
                st.armed <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt_inc[DT_W-1:0];
            end
        end
    end

    assign drive = st.on;
    assign armed = st.armed;
endmodule

// File: rtl/pwm_deadband_gen.sv
module pwm_deadband_gen
    import pwm_db_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            chan_en,
    input  logic            cmp_in,
    input  logic            period_end,
    input  logic            en_wr,
    input  logic            en_wdata,
    input  logic            upd_wr,
    input  logic [DT_W-1:0] upd_hi,
    input  logic [DT_W-1:0] upd_lo,
    input  logic            inv_hi,
    input  logic            inv_lo,
    output logic            out_hi,
    output logic            out_lo
);
    localparam int NSIDE = 2;

    logic            db_on;
    logic [DT_W-1:0] work [NSIDE];
    logic [NSIDE-1:0] raw;
    logic [NSIDE-1:0] pend;
    logic [NSIDE-1:0] inv;

    assign inv = {inv_lo, inv_hi};

    pwm_db_enable u_en (
        .clk     (clk),
        .rst     (rst),
        .chan_en (chan_en),
        .wr      (en_wr),
        .wdata   (en_wdata),
        .db_on   (db_on)
    );

    pwm_db_shadow #(.DT_W(DT_W)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .upd_wr     (upd_wr),
        .upd_hi     (upd_hi),
        .upd_lo     (upd_lo),
        .period_end (period_end),
        .work_hi    (work[0]),
        .work_lo    (work[1])
    );

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        pwm_db_side #(
            .DT_W (DT_W),
            .SIDE ((i == 0) ? SIDE_HI : SIDE_LO)
        ) u_side (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .db_on  (db_on),
            .cmp_in (cmp_in),
            .dt_val (work[i]),
            .drive  (raw[i]),
            .armed  (pend[i])
        );
    end

    assign out_hi = raw[0] ^ inv[0];
    assign out_lo = raw[1] ^ inv[1];
endmodule

// File: rtl/pwm_db_checker.sv
module pwm_db_checker #(
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            tick,
    input logic            chan_en,
    input logic            cmp_in,
    input logic            period_end,
    input logic            db_on,
    input logic            raw_hi,
    input logic            raw_lo,
    input logic            pend_hi,
    input logic [DT_W-1:0] work_hi,
    input logic [DT_W-1:0] work_lo
);
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(raw_hi && raw_lo));

    assert_hi_off_fast_R3: assert property (@(posedge clk) disable iff (rst)
        !cmp_in |=> !raw_hi);

    assert_lo_off_fast_R3: assert property (@(posedge clk) disable iff (rst)
        cmp_in |=> !raw_lo);

    assert_passthru_R1: assert property (@(posedge clk) disable iff (rst)
        !db_on |=> (raw_hi == $past(cmp_in)) && (raw_lo == !$past(cmp_in)));

    assert_no_tick_no_step_R6: assert property (@(posedge clk) disable iff (rst)
        (db_on && cmp_in && pend_hi && !tick) |=> !raw_hi);

    assert_enable_locked_R10: assert property (@(posedge clk) disable iff (rst)
        chan_en |=> $stable(db_on));

    assert_work_held_R9: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(work_hi) && $stable(work_lo));
endmodule

bind pwm_deadband_gen pwm_db_checker #(.DT_W(DT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .chan_en    (chan_en),
    .cmp_in     (cmp_in),
    .period_end (period_end),
    .db_on      (db_on),
    .raw_hi     (raw[0]),
    .raw_lo     (raw[1]),
    .pend_hi    (pend[0]),
    .work_hi    (work[0]),
    .work_lo    (work[1])
);

// File: tb/pwm_deadband_gen_tb.sv
module pwm_deadband_gen_tb;
    localparam int DT_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tick = 1'b1;
    logic            chan_en = 1'b0;
    logic            cmp_in = 1'b0;
    logic            period_end = 1'b0;
    logic            en_wr = 1'b0;
    logic            en_wdata = 1'b0;
    logic            upd_wr = 1'b0;
    logic [DT_W-1:0] upd_hi = '0;
    logic [DT_W-1:0] upd_lo = '0;
    logic            inv_hi = 1'b0;
    logic            inv_lo = 1'b0;
    logic            out_hi;
    logic            out_lo;

    int  cyc = 0;
    bit  slow = 1'b0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int    cyc;
        bit    hi;
        bit    lo;
        string tag;
    } exp_t;
    exp_t q[$];
    exp_t mon_e;

    pwm_deadband_gen #(.DT_W(DT_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .chan_en    (chan_en),
        .cmp_in     (cmp_in),
        .period_end (period_end),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .upd_wr     (upd_wr),
        .upd_hi     (upd_hi),
        .upd_lo     (upd_lo),
        .inv_hi     (inv_hi),
        .inv_lo     (inv_lo),
        .out_hi     (out_hi),
        .out_lo     (out_lo)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // tick seen at posedge P is set at the negedge before it (cyc == P-1)
    always @(negedge clk) tick <= slow ? ((cyc % 4) == 0) : 1'b1;

    function automatic bit tick_at(int p);
        return slow ? ((p % 4) == 1) : 1'b1;
    endfunction

    task automatic chk(string tag, bit ah, bit al, bit eh, bit el);
        n_chk++;
        if (ah !== eh || al !== el) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: out_hi/out_lo=%b%b expected %b%b",
                     tag, cyc, ah, al, eh, el);
        end
    endtask

    function automatic void push(int c, bit rh, bit rl, string tag);
        exp_t e;
        e.cyc = c;
        e.hi  = rh ^ inv_hi;
        e.lo  = rl ^ inv_lo;
        e.tag = tag;
        q.push_back(e);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            mon_e = q.pop_front();
            if (mon_e.cyc == cyc) begin
                chk(mon_e.tag, out_hi, out_lo, mon_e.hi, mon_e.lo);
            end else begin
                n_chk++;
                n_fail++;
                $display("FAIL %s: expectation for cycle %0d missed, now %0d",
                         mon_e.tag, mon_e.cyc, cyc);
            end
        end
    end

    // drive a compare edge and queue the expected drive waveform
    task automatic cmp_edge(bit v, int d, string tag);
        int c;
        int p;
        int k;
        @(negedge clk);
        c = cyc;
        cmp_in = v;
        if (d == 0) begin
            push(c + 1, v, !v, tag);
            p = c + 1;
        end else begin
            push(c + 1, 1'b0, 1'b0, "R3 off-side drop");
            p = c + 1;
            k = 0;
            while (k < d) begin
                p++;
                if (tick_at(p)) k++;
            end
            if (p - 1 > c + 1) push(p - 1, 1'b0, 1'b0, "R2 gap");
            push(p, v, !v, tag);
        end
        repeat (p - c + 2) @(negedge clk);
    endtask

    task automatic stage(int h, int l);
        @(negedge clk);
        upd_wr = 1'b1;
        upd_hi = DT_W'(h);
        upd_lo = DT_W'(l);
        @(negedge clk);
        upd_wr = 1'b0;
    endtask

    task automatic pulse_period;
        @(negedge clk);
        period_end = 1'b1;
        @(negedge clk);
        period_end = 1'b0;
    endtask

    task automatic write_en(bit v);
        @(negedge clk);
        en_wr = 1'b1;
        en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk("R12 reset", out_hi, out_lo, 1'b0, 1'b0);
        inv_hi = 1'b1;
        inv_lo = 1'b1;
        #1;
        chk("R12 reset inverted", out_hi, out_lo, 1'b1, 1'b1);
        @(negedge clk);
        inv_hi = 1'b0;
        inv_lo = 1'b0;
        rst = 1'b0;

        // R1: dead-band off, straight pass
        cmp_edge(1'b1, 0, "R1 rise");
        cmp_edge(1'b0, 0, "R1 fall");

        // R10: enable while channel stopped
        write_en(1'b1);
        // R9: staged values do not act yet
        stage(3, 5);
        cmp_edge(1'b1, 0, "R9 not yet loaded rise");
        cmp_edge(1'b0, 0, "R9 not yet loaded fall");
        pulse_period();
        @(negedge clk);
        chan_en = 1'b1;

        // R4 / R5 independent delays
        cmp_edge(1'b1, 3, "R4 high delay");
        cmp_edge(1'b0, 5, "R5 low delay");

        // R10: enable write ignored while running
        write_en(1'b0);
        cmp_edge(1'b1, 3, "R10 ignored write rise");
        cmp_edge(1'b0, 5, "R10 ignored write fall");

        // R8: reversal before expiry
        @(negedge clk);
        c = cyc;
        cmp_in = 1'b1;
        push(c + 1, 1'b0, 1'b0, "R8 armed");
        @(negedge clk);
        @(negedge clk);
        cmp_in = 1'b0;
        for (int i = 2; i <= 7; i++) push(c + i, 1'b0, 1'b0, "R8 pending dropped");
        push(c + 8, 1'b0, 1'b1, "R8 low fresh delay");
        repeat (10) @(negedge clk);

        // R6: slow tick
        @(negedge clk);
        slow = 1'b1;
        repeat (5) @(negedge clk);
        cmp_edge(1'b1, 3, "R6 slow tick rise");
        cmp_edge(1'b0, 5, "R6 slow tick fall");
        @(negedge clk);
        slow = 1'b0;
        repeat (3) @(negedge clk);

        // R11: high output inverted only
        @(negedge clk);
        inv_hi = 1'b1;
        cmp_edge(1'b1, 3, "R11 inverted high rise");
        cmp_edge(1'b0, 5, "R11 inverted high fall");
        @(negedge clk);
        inv_hi = 1'b0;
        inv_lo = 1'b1;
        cmp_edge(1'b1, 3, "R11 inverted low rise");
        @(negedge clk);
        inv_lo = 1'b0;

        // R7: zero high wait, short low wait
        stage(0, 2);
        pulse_period();
        cmp_edge(1'b0, 2, "R7 low wait 2");
        cmp_edge(1'b1, 0, "R7 zero wait");

        // back to pass-through
        @(negedge clk);
        chan_en = 1'b0;
        write_en(1'b0);
        cmp_edge(1'b0, 0, "R1 disabled again fall");
        cmp_edge(1'b1, 0, "R1 disabled again rise");

        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run still busy at cycle %0d, expected done", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule